// File: doc/BRIEF.md
# Holdover Frequency History Store

This block keeps the frequency history that a timing loop falls back on when it loses its reference. While the loop is locked it receives frequency samples with a valid strobe. It sums them in an accumulator until a build of a set length completes. At that point the mean becomes the active history, which is what holdover uses. After the first build, every new sample updates a running mean, and the active history follows it on the same clock edge.

A second copy, the backup history, can be written from the active history and later restored into it. A flush clears the active history and the accumulator but leaves the backup alone. A policy bit decides what a reference switch does to the accumulator: it either restarts the build or carries on. A saturating counter of whole hours spent in holdover runs next to the store.

Top module: `hhist_top`

## Requirements
- R1: After reset the active history is 0, both flags are 0, the latched command is 00, the policy is 0 (rebuild) and the hours count is 0.
- R2: A sample is accepted when `smp_vld_i` is high and no command, holdover or rebuild-switch blocks it. On the edge that takes the BUILD_LEN-th accepted sample since the last restart, `active_o` becomes floor(sum/BUILD_LEN), and `avail_o` and `built_o` go to 1. `built_o` high always implies `avail_o` high.
- R3: Once built, each accepted sample s changes the sum to sum − floor(sum/BUILD_LEN) + s, and `active_o` becomes floor(new sum/BUILD_LEN) on the same edge.
- R4: A pulse on `cmd_wr_i` latches `cmd_i` into `last_cmd_o` on the next edge. The codes are 00 none, 01 save, 10 restore and 11 flush. Only code 00 loads `policy_i` into `policy_o`; the other codes leave the policy unchanged.
- R5: Save (01) copies the active history into the backup. The backup counts as written only if `avail_o` was 1 at the time of the save.
- R6: Restore (10) loads the active history from the backup and sets `avail_o` to the backup's written mark. It also clears the accumulator, so `built_o` goes to 0 and a full new build is needed.
- R7: Flush (11) sets the active history to 0, clears `avail_o` and `built_o`, and empties the accumulator. The backup is not changed.
- R8: With policy 0, a `ref_sw_i` pulse restarts the accumulator: `built_o` goes to 0, `active_o` and `avail_o` are kept, and any sample in that cycle is dropped. With policy 1, the pulse has no effect.
- R9: While `holdover_i` is high, samples are ignored and `active_o` holds its value. This includes the case where no history is available.
- R10: `hours_o` reads 0 one cycle after any cycle with `holdover_i` low. In holdover it counts `hour_tick_i` pulses and stops at 255.
- R11: In a cycle with `cmd_wr_i` high, any sample and any reference switch in that same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Frequency sample strobe, locked operation |
| smp_i | input | SAMPLE_W | Unsigned frequency sample |
| ref_sw_i | input | 1 | Reference switch pulse |
| holdover_i | input | 1 | Loop is in holdover |
| hour_tick_i | input | 1 | One pulse per hour |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command code |
| policy_i | input | 1 | Policy bit, loaded with command 00 |
| active_o | output | SAMPLE_W | Active history value |
| avail_o | output | 1 | Active history available |
| built_o | output | 1 | Accumulator build complete |
| last_cmd_o | output | 2 | Last latched command |
| policy_o | output | 1 | Current switch policy (0 rebuild, 1 continue) |
| hours_o | output | HOURS_W | Whole hours in holdover, saturating |

## Verification
The bench builds the block with SAMPLE_W = 12 and BUILD_LEN = 4. A build therefore completes after four samples, so restarts, flushes, restores and running-mean updates can all be reached within a few dozen cycles. HOURS_MAX stays at 255, which lets the bench drive the counter into saturation and keep it there with extra ticks. A long random phase then mixes commands, switches and holdover against the reference model on every clock.

// File: rtl/hhist_pkg.sv
package hhist_pkg;

    typedef enum logic [1:0] {
        HC_NONE    = 2'b00,
        HC_SAVE    = 2'b01,
        HC_RESTORE = 2'b10,
        HC_FLUSH   = 2'b11
    } hc_cmd_e;

endpackage

// File: rtl/hhist_accum.sv
module hhist_accum #(
    parameter int SAMPLE_W  = 16,
    parameter int BUILD_LEN = 900
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                take_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                load_o,
    output logic [SAMPLE_W-1:0] mean_o,
    output logic                built_o
);
    localparam int CNT_W = $clog2(BUILD_LEN + 1);
    localparam int SUM_W = SAMPLE_W + CNT_W;
    localparam logic [SUM_W-1:0] DIV  = SUM_W'(BUILD_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUILD_LEN);

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             built;
    } acc_t;

    acc_t             acc_d, acc_q;
    logic [SUM_W-1:0] sum_upd;
    logic [SUM_W-1:0] smp_ext;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        acc_d   = acc_q;
        load_o  = 1'b0;
        smp_ext = SUM_W'(sample_i);
        cnt_inc = acc_q.cnt + 1'b1;
        sum_upd = acc_q.sum;
        if (clr_i) begin
            acc_d.sum   = '0;
            acc_d.cnt   = '0;
            acc_d.built = 1'b0;
        end else if (take_i) begin
            if (acc_q.built) begin
                // running mean of fixed length: drop one average share
                sum_upd   = acc_q.sum - (acc_q.sum / DIV) + smp_ext;
                acc_d.sum = sum_upd;
                load_o    = 1'b1;
            end else begin
                sum_upd   = acc_q.sum + smp_ext;
                acc_d.sum = sum_upd;
                acc_d.cnt = cnt_inc;
                if (cnt_inc == LAST) begin
                    acc_d.built = 1'b1;
                    load_o      = 1'b1;
                end
            end
        end
        mean_o = SAMPLE_W'(sum_upd / DIV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign built_o = acc_q.built;

endmodule

// File: rtl/hhist_store.sv
module hhist_store #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] mean_i,
    input  logic                save_i,
    input  logic                restore_i,
    input  logic                flush_i,
    output logic [SAMPLE_W-1:0] active_o,
    output logic                avail_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] active;
        logic                avail;
        logic [SAMPLE_W-1:0] backup;
        logic                bk_written;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.active = '0;
            st_d.avail  = 1'b0;
        end else if (restore_i) begin
            st_d.active = st_q.backup;
            st_d.avail  = st_q.bk_written;
        end else if (save_i) begin
            st_d.backup     = st_q.active;
            st_d.bk_written = st_q.avail;
        end else if (load_i) begin
            st_d.active = mean_i;
            st_d.avail  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign avail_o  = st_q.avail;

endmodule

// File: rtl/hhist_hours.sv
module hhist_hours #(
    parameter int HOURS_MAX = 255,
    parameter int HOURS_W   = $clog2(HOURS_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               holdover_i,
    input  logic               tick_i,
    output logic [HOURS_W-1:0] hours_o
);
    localparam logic [HOURS_W-1:0] TOP = HOURS_W'(HOURS_MAX);

    logic [HOURS_W-1:0] hrs_d, hrs_q;

    always_comb begin
        hrs_d = hrs_q;
        if (!holdover_i) begin
            hrs_d = '0;
        end else if (tick_i && (hrs_q != TOP)) begin
            hrs_d = hrs_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hrs_q <= '0;
        end else begin
            hrs_q <= hrs_d;
        end
    end

    assign hours_o = hrs_q;

endmodule

// File: rtl/hhist_top.sv
module hhist_top #(
    parameter int SAMPLE_W  = 16,
    parameter int BUILD_LEN = 900,
    parameter int HOURS_MAX = 255,
    parameter int HOURS_W   = $clog2(HOURS_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                ref_sw_i,
    input  logic                holdover_i,
    input  logic                hour_tick_i,
    input  logic                cmd_wr_i,
    input  logic [1:0]          cmd_i,
    input  logic                policy_i,
    output logic [SAMPLE_W-1:0] active_o,
    output logic                avail_o,
    output logic                built_o,
    output logic [1:0]          last_cmd_o,
    output logic                policy_o,
    output logic [HOURS_W-1:0]  hours_o
);
    import hhist_pkg::*;

    typedef struct packed {
        hc_cmd_e last_cmd;
        logic    policy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    hc_cmd_e             cmd_code;
    logic                do_save, do_restore, do_flush;
    logic                sw_rebuild, acc_clr, acc_take;
    logic                acc_load;
    logic [SAMPLE_W-1:0] acc_mean;

    always_comb begin
        cmd_code   = hc_cmd_e'(cmd_i);
        do_save    = cmd_wr_i && (cmd_code == HC_SAVE);
        do_restore = cmd_wr_i && (cmd_code == HC_RESTORE);
        do_flush   = cmd_wr_i && (cmd_code == HC_FLUSH);
        // a command owns its cycle: switch and sample are dropped
        sw_rebuild = !cmd_wr_i && ref_sw_i && !ctl_q.policy;
        acc_clr    = do_restore || do_flush || sw_rebuild;
        acc_take   = smp_vld_i && !holdover_i && !cmd_wr_i && !sw_rebuild;

        ctl_d = ctl_q;
        if (cmd_wr_i) begin
            ctl_d.last_cmd = cmd_code;
            if (cmd_code == HC_NONE) begin
                ctl_d.policy = policy_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{last_cmd: HC_NONE, policy: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    hhist_accum #(
        .SAMPLE_W (SAMPLE_W),
        .BUILD_LEN(BUILD_LEN)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (acc_clr),
        .take_i  (acc_take),
        .sample_i(smp_i),
        .load_o  (acc_load),
        .mean_o  (acc_mean),
        .built_o (built_o)
    );

    hhist_store #(
        .SAMPLE_W(SAMPLE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (acc_load),
        .mean_i   (acc_mean),
        .save_i   (do_save),
        .restore_i(do_restore),
        .flush_i  (do_flush),
        .active_o (active_o),
        .avail_o  (avail_o)
    );

    hhist_hours #(
        .HOURS_MAX(HOURS_MAX),
        .HOURS_W  (HOURS_W)
    ) u_hours (
        .clk       (clk),
        .rst_n     (rst_n),
        .holdover_i(holdover_i),
        .tick_i    (hour_tick_i),
        .hours_o   (hours_o)
    );

    assign last_cmd_o = ctl_q.last_cmd;
    assign policy_o   = ctl_q.policy;

endmodule

// File: rtl/hhist_chk.sv
module hhist_chk #(
    parameter int SAMPLE_W  = 16,
    parameter int HOURS_MAX = 255,
    parameter int HOURS_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_sw_i,
    input logic                holdover_i,
    input logic                cmd_wr_i,
    input logic [1:0]          cmd_i,
    input logic [SAMPLE_W-1:0] active_o,
    input logic                avail_o,
    input logic                built_o,
    input logic [1:0]          last_cmd_o,
    input logic                policy_o,
    input logic [HOURS_W-1:0]  hours_o
);
    localparam logic [HOURS_W-1:0] TOP = HOURS_W'(HOURS_MAX);

    assert_built_avail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        built_o |-> avail_o);

    assert_cmd_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> last_cmd_o == $past(cmd_i));

    assert_policy_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr_i && cmd_i == 2'b00) |=> $stable(policy_o));

    assert_restore_rebuild_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b10) |=> !built_o);

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b11) |=> (!avail_o && !built_o && active_o == '0));

    assert_switch_rebuild_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sw_i && !cmd_wr_i && !policy_o) |=> (!built_o && $stable(avail_o) && $stable(active_o)));

    assert_holdover_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover_i && !cmd_wr_i) |=> $stable(active_o));

    assert_hours_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !holdover_i |=> hours_o == '0);

    assert_hours_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover_i && hours_o == TOP) |=> hours_o == TOP);

    assert_save_drops_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b01) |=> ($stable(active_o) && $stable(built_o)));

endmodule

bind hhist_top hhist_chk #(
    .SAMPLE_W (SAMPLE_W),
    .HOURS_MAX(HOURS_MAX),
    .HOURS_W  (HOURS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_sw_i  (ref_sw_i),
    .holdover_i(holdover_i),
    .cmd_wr_i  (cmd_wr_i),
    .cmd_i     (cmd_i),
    .active_o  (active_o),
    .avail_o   (avail_o),
    .built_o   (built_o),
    .last_cmd_o(last_cmd_o),
    .policy_o  (policy_o),
    .hours_o   (hours_o)
);

// File: tb/tb_hhist_top.sv
`timescale 1ns/1ps
module tb_hhist_top;
    localparam int SW = 12;
    localparam int N  = 4;
    localparam int HM = 255;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [SW-1:0] smp = '0;
    logic          ref_sw = 1'b0;
    logic          holdover = 1'b0;
    logic          tick = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic          pol = 1'b0;
    logic [SW-1:0] active;
    logic          avail, built, policy;
    logic [1:0]    last_cmd;
    logic [HW-1:0] hours;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit live = 0;

    // reference model state
    int m_sum, m_cnt, m_active, m_bk, m_hours, m_last;
    bit m_built, m_avail, m_bkv, m_pol;

    always #2.5 clk = ~clk;

    hhist_top #(.SAMPLE_W(SW), .BUILD_LEN(N), .HOURS_MAX(HM), .HOURS_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_i(smp),
        .ref_sw_i(ref_sw), .holdover_i(holdover), .hour_tick_i(tick),
        .cmd_wr_i(cmd_wr), .cmd_i(cmd), .policy_i(pol),
        .active_o(active), .avail_o(avail), .built_o(built),
        .last_cmd_o(last_cmd), .policy_o(policy), .hours_o(hours)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_restart();
        m_sum = 0; m_cnt = 0; m_built = 0;
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_restart();
            m_active = 0; m_avail = 0; m_bk = 0; m_bkv = 0;
            m_hours = 0; m_last = 0; m_pol = 0;
        end else begin
            bit rebuild, take;
            rebuild = ref_sw && !m_pol && !cmd_wr;
            take    = smp_vld && !holdover && !cmd_wr && !rebuild;
            if (!holdover) m_hours = 0;
            else if (tick && m_hours < HM) m_hours = m_hours + 1;
            if (cmd_wr) begin
                m_last = cmd;
                case (cmd)
                    2'b00: m_pol = pol;
                    2'b01: begin m_bk = m_active; m_bkv = m_avail; end
                    2'b10: begin m_active = m_bk; m_avail = m_bkv; m_restart(); end
                    default: begin m_active = 0; m_avail = 0; m_restart(); end
                endcase
            end else if (rebuild) begin
                m_restart();
            end else if (take) begin
                if (m_built) begin
                    m_sum = m_sum - m_sum / N + int'(smp);
                    m_active = m_sum / N;
                end else begin
                    m_sum = m_sum + int'(smp);
                    m_cnt = m_cnt + 1;
                    if (m_cnt == N) begin
                        m_built = 1; m_avail = 1; m_active = m_sum / N;
                    end
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R2 R3 active", int'(active), m_active);
            chk("R2 avail", int'(avail), int'(m_avail));
            chk("R2 built", int'(built), int'(m_built));
            chk("R4 last_cmd", int'(last_cmd), m_last);
            chk("R4 policy", int'(policy), int'(m_pol));
            chk("R10 hours", int'(hours), m_hours);
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic samp(input int v);
        smp_vld = 1'b1; smp = SW'(v);
        cyc();
        smp_vld = 1'b0;
    endtask

    task automatic command(input logic [1:0] c, input logic p);
        cmd_wr = 1'b1; cmd = c; pol = p;
        cyc();
        cmd_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) cyc();
        rst_n = 1'b1;
        live  = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 active", int'(active), 0);
        chk("R1 avail", int'(avail), 0);
        chk("R1 built", int'(built), 0);
        chk("R1 last_cmd", int'(last_cmd), 0);
        chk("R1 policy", int'(policy), 0);
        chk("R1 hours", int'(hours), 0);

        // R2 build
        samp(100); samp(200); samp(300);
        chk("R2 not yet built", int'(built), 0);
        chk("R2 not yet avail", int'(avail), 0);
        samp(400);
        chk("R2 mean", int'(active), 250);
        chk("R2 built", int'(built), 1);
        chk("R2 avail", int'(avail), 1);
        // R3 running mean: 1000-250+50 = 800 -> 200
        samp(50);
        chk("R3 running", int'(active), 200);

        // R5 save, R7 flush, R6 restore
        command(2'b01, 1'b0);
        chk("R4 latched save", int'(last_cmd), 1);
        command(2'b11, 1'b0);
        chk("R7 active", int'(active), 0);
        chk("R7 avail", int'(avail), 0);
        chk("R7 built", int'(built), 0);
        command(2'b10, 1'b0);
        chk("R6 R7 R5 backup kept", int'(active), 200);
        chk("R6 avail from backup", int'(avail), 1);
        chk("R6 built cleared", int'(built), 0);

        // R8 rebuild policy
        samp(10); samp(10);
        ref_sw = 1'b1; cyc(); ref_sw = 1'b0;
        samp(8); samp(8);
        chk("R8 restarted", int'(built), 0);
        chk("R8 active kept", int'(active), 200);
        chk("R8 avail kept", int'(avail), 1);
        samp(8); samp(8);
        chk("R8 rebuilt mean", int'(active), 8);

        // R4 policy load only by 00
        command(2'b00, 1'b1);
        chk("R4 policy set", int'(policy), 1);
        command(2'b01, 1'b0);
        chk("R4 policy kept", int'(policy), 1);
        // R8 continue: switch with sample, 32-8+12 = 36 -> 9
        ref_sw = 1'b1; samp(12); ref_sw = 1'b0;
        chk("R8 continue built", int'(built), 1);
        chk("R8 continue mean", int'(active), 9);

        // R11 restore with sample in the same cycle: sample dropped
        smp_vld = 1'b1; smp = 12'd100;
        command(2'b10, 1'b1);
        smp_vld = 1'b0;
        chk("R11 restore value", int'(active), 8);
        samp(4); samp(4); samp(4);
        chk("R11 sample dropped", int'(built), 0);
        samp(4);
        chk("R11 build after", int'(active), 4);

        // R9 holdover freezes active; R10 hours
        holdover = 1'b1;
        samp(1000);
        chk("R9 holdover ignores", int'(active), 4);
        tick = 1'b1;
        repeat (3) cyc();
        chk("R10 count", int'(hours), 3);
        repeat (260) cyc();
        chk("R10 saturate", int'(hours), 255);
        tick = 1'b0;
        command(2'b11, 1'b0);
        samp(500);
        chk("R9 no history held", int'(active), 0);
        holdover = 1'b0;
        cyc();
        chk("R10 cleared", int'(hours), 0);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            smp_vld  = ($urandom % 3) != 0;
            smp      = SW'($urandom);
            ref_sw   = ($urandom % 23) == 0;
            cmd_wr   = ($urandom % 19) == 0;
            cmd      = 2'($urandom);
            pol      = 1'($urandom);
            tick     = ($urandom % 4) == 0;
            if (($urandom % 97) == 0) holdover = ~holdover;
            cyc();
        end
        smp_vld = 0; ref_sw = 0; cmd_wr = 0; tick = 0; holdover = 0;
        cyc();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule